// File: doc/BRIEF.md
# Serial Audio Transmit Port with Word Buffer and Mute

This block drives one serial audio output line in the common two-channel I2S format. It takes 24-bit audio samples from a small first-in first-out buffer and shifts them out one bit per bit clock, most significant bit first. The bit clock and the left/right word-select clock are generated elsewhere and shared by all transmit ports. The port sees the bit clock as a one-cycle strobe in the system clock domain that marks each falling edge, and it samples the word-select level on that strobe.

Samples enter the buffer from one of two write ports. The first is a direct port driven by software register writes. The second is a streaming port driven by a DMA engine, which the block asks for more data while the buffer runs low. A mode input selects which port is live. Mute replaces the outgoing samples with silence while still draining the buffer, so the data stays aligned with the frame. A clear input empties the buffer at once. A loopback input steers the port's own serial output onto the receive-side data input for self-test. A sticky flag records any word slot that found the buffer empty.

Top module: `i2s_tx_port`

## Requirements
- R1: Each word-select change seen on a bit-clock falling-edge strobe starts a new word. Its 24 bits leave MSB first, the MSB on the next falling-edge strobe (one bit clock after the change). Every later slot of that half-frame carries 0.
- R2: The buffer holds up to 16 words of 24 bits and delivers them in write order. A write while 16 words are held is discarded.
- R3: `fifo_empty` is 1 exactly when no word is held, and `fifo_full` is 1 exactly when 16 words are held.
- R4: While `mute` is 1 at a word start, the word is still taken from the buffer, but 24 zero bits are sent in its place.
- R5: When `dma_mode` is 0, only `cpu_wr`/`cpu_wdata` write the buffer. When it is 1, only `dma_wr`/`dma_wdata` do. A strobe on the other port has no effect.
- R6: `dma_req` is 1 exactly when `dma_mode` is 1 and the buffer holds 8 words or fewer.
- R7: If `tx_en` is 1 and the buffer is empty at a word start, zeros are sent and `underrun` goes to 1. It stays at 1 until a clear.
- R8: `clr_fifo` held for one cycle empties the buffer and clears `underrun` by the next cycle. A write in that same cycle is lost.
- R9: While `tx_en` is 0, word starts take nothing from the buffer, and zeros are sent.
- R10: `rx_sd_mux` equals `sd_out` when `loopback` is 1, and equals `rx_sd_in` when it is 0.
- R11: `sd_out` is registered. It changes only in the cycle after a falling-edge strobe and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| mute | input | 1 | Send silence while still consuming words |
| clr_fifo | input | 1 | Empty the buffer and clear the underrun flag |
| dma_mode | input | 1 | 1 selects the DMA write port, 0 the direct port |
| loopback | input | 1 | Route serial output onto the receive data path |
| cpu_wr | input | 1 | Direct-port write strobe |
| cpu_wdata | input | 24 | Direct-port sample |
| dma_wr | input | 1 | DMA-port write strobe |
| dma_wdata | input | 24 | DMA-port sample |
| bclk_fall | input | 1 | One-cycle strobe per bit-clock falling edge |
| lrclk | input | 1 | Word-select level, sampled on the strobe |
| rx_sd_in | input | 1 | External receive serial data |
| sd_out | output | 1 | Serial audio output |
| rx_sd_mux | output | 1 | Serial data presented to the receiver |
| fifo_full | output | 1 | Buffer holds 16 words |
| fifo_empty | output | 1 | Buffer holds no word |
| underrun | output | 1 | Sticky: a word start found the buffer empty |
| dma_req | output | 1 | Request for more data in DMA mode |

## Verification
The bench goes after the word boundary. A design that put the MSB in the same slot as the word-select change, or that leaked stale bits into slots 25 to 32, would miss the bit-by-bit compare. Writes past 16 words and writes on the inactive port are checked through the order of the words that later leave the line. A buffer that kept or shifted those words would put a wrong sample on the line. Mute and the disabled state are told apart by what follows them. A muted design that failed to pop would send a stale word once unmuted. A disabled one that popped would empty the buffer too early. The request threshold is probed at exactly 8 and 9 held words, and the underrun flag must survive refills and drop only on clear.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    localparam int unsigned SAMPLE_W   = 24;
    localparam int unsigned BUF_DEPTH  = 16;
    localparam int unsigned DMA_THRESH = 8;
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int unsigned W     = 24,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + AW'(1);
    endfunction

    always_comb begin
        logic do_wr;
        logic do_rd;
        st_d  = st_q;
        do_wr = wr && (st_q.cnt != CW'(DEPTH));
        do_rd = rd && (st_q.cnt != '0);
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_wr) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = bump(st_q.wp);
            end
            if (do_rd) begin
                st_d.rp = bump(st_q.rp);
            end
            if (do_wr && !do_rd) st_d.cnt = st_q.cnt + CW'(1);
            else if (!do_wr && do_rd) st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rp];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd && !clr) |=> full);
    assert_flags_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer #(
    parameter int unsigned W  = 24,
    localparam int unsigned LW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk_fall,
    input  logic         lrclk,
    input  logic         tx_en,
    input  logic         mute,
    input  logic         clr,
    input  logic         empty,
    input  logic [W-1:0] word,
    output logic         pop,
    output logic         sd,
    output logic         urun
);
    typedef struct packed {
        logic          lr;
        logic [W-1:0]  sh;
        logic [LW-1:0] left;
        logic          sd;
        logic          urun;
    } ser_st_t;

    ser_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (bclk_fall) begin
            st_d.lr = lrclk;
            st_d.sd = (st_q.left != '0) ? st_q.sh[W-1] : 1'b0;
            if (st_q.left != '0) begin
                st_d.sh   = {st_q.sh[W-2:0], 1'b0};
                st_d.left = st_q.left - LW'(1);
            end
            if (lrclk != st_q.lr) begin
                st_d.left = LW'(W);
                st_d.sh   = '0;
                if (tx_en) begin
                    if (!empty) begin
                        pop = 1'b1;
                        if (!mute) st_d.sh = word;
                    end else begin
                        st_d.urun = 1'b1;
                    end
                end
            end
        end
        if (clr) st_d.urun = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sd   = st_q.sd;
    assign urun = st_q.urun;

    assert_tail_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_fall && st_q.left == '0) |=> !sd);
    assert_sticky_urun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (urun && !clr) |=> urun);
    assert_no_pop_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !pop);
    assert_sd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_fall |=> $stable(sd));
endmodule

// File: rtl/i2s_tx_port.sv
module i2s_tx_port
    import i2s_tx_pkg::*;
#(
    parameter int unsigned W      = SAMPLE_W,
    parameter int unsigned DEPTH  = BUF_DEPTH,
    parameter int unsigned THRESH = DMA_THRESH,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en,
    input  logic         mute,
    input  logic         clr_fifo,
    input  logic         dma_mode,
    input  logic         loopback,
    input  logic         cpu_wr,
    input  logic [W-1:0] cpu_wdata,
    input  logic         dma_wr,
    input  logic [W-1:0] dma_wdata,
    input  logic         bclk_fall,
    input  logic         lrclk,
    input  logic         rx_sd_in,
    output logic         sd_out,
    output logic         rx_sd_mux,
    output logic         fifo_full,
    output logic         fifo_empty,
    output logic         underrun,
    output logic         dma_req
);
    logic          wr_sel;
    logic [W-1:0]  wdata_sel;
    logic          pop;
    logic [W-1:0]  head;
    logic [CW-1:0] level;

    always_comb begin
        wr_sel    = dma_mode ? dma_wr    : cpu_wr;
        wdata_sel = dma_mode ? dma_wdata : cpu_wdata;
    end

    i2s_tx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_fifo),
        .wr    (wr_sel),
        .wdata (wdata_sel),
        .rd    (pop),
        .rdata (head),
        .count (level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    i2s_tx_serializer #(.W(W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_fall (bclk_fall),
        .lrclk     (lrclk),
        .tx_en     (tx_en),
        .mute      (mute),
        .clr       (clr_fifo),
        .empty     (fifo_empty),
        .word      (head),
        .pop       (pop),
        .sd        (sd_out),
        .urun      (underrun)
    );

    assign dma_req   = dma_mode && (level <= CW'(THRESH));
    assign rx_sd_mux = loopback ? sd_out : rx_sd_in;

    assert_clear_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fifo |=> (fifo_empty && !underrun));
    assert_req_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_mode) |-> 1'b0);
    assert_req_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_mode && fifo_empty) |-> dma_req);
endmodule

// File: tb/tb_i2s_tx_port.sv
module tb_i2s_tx_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_en, mute, clr_fifo, dma_mode, loopback;
    logic        cpu_wr, dma_wr, bclk_fall, lrclk, rx_sd_in;
    logic [23:0] cpu_wdata, dma_wdata;
    logic        sd_out, rx_sd_mux, fifo_full, fifo_empty, underrun, dma_req;

    int n_tests = 0;
    int n_fail  = 0;

    logic [23:0] m_q[$];
    logic [23:0] m_sh;
    int          m_left;
    logic        m_prev;
    logic        m_urun;

    always #4 clk = ~clk;

    i2s_tx_port dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mute(mute), .clr_fifo(clr_fifo),
        .dma_mode(dma_mode), .loopback(loopback), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .bclk_fall(bclk_fall), .lrclk(lrclk),
        .rx_sd_in(rx_sd_in), .sd_out(sd_out), .rx_sd_mux(rx_sd_mux), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .underrun(underrun), .dma_req(dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_status();
        chk("R3 empty", 32'(fifo_empty), 32'(m_q.size() == 0));
        chk("R3 full", 32'(fifo_full), 32'(m_q.size() == 16));
        chk("R6 dma_req", 32'(dma_req), 32'(dma_mode && m_q.size() <= 8));
        chk("R7 underrun", 32'(underrun), 32'(m_urun));
    endtask

    task automatic push(input logic [23:0] d, input logic via_dma);
        @(negedge clk);
        if (via_dma) begin dma_wr = 1'b1; dma_wdata = d; end
        else         begin cpu_wr = 1'b1; cpu_wdata = d; end
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0;
        dma_wr = 1'b0;
        if ((via_dma == dma_mode) && m_q.size() < 16) m_q.push_back(d);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_fifo = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_fifo = 1'b0;
        m_q.delete();
        m_urun = 1'b0;
    endtask

    task automatic tick(input logic lr);
        logic exp;
        @(negedge clk);
        bclk_fall = 1'b1;
        lrclk     = lr;
        rx_sd_in  = 1'($urandom());
        exp = (m_left != 0) ? m_sh[23] : 1'b0;
        if (m_left != 0) begin m_sh = m_sh << 1; m_left--; end
        if (lr != m_prev) begin
            m_left = 24;
            m_sh   = '0;
            if (tx_en) begin
                if (m_q.size() > 0) begin
                    logic [23:0] w;
                    w = m_q.pop_front();
                    if (!mute) m_sh = w;
                end else m_urun = 1'b1;
            end
        end
        m_prev = lr;
        @(posedge clk);
        @(negedge clk);
        bclk_fall = 1'b0;
        chk("R1 serial bit", 32'(sd_out), 32'(exp));
        chk("R10 loopback mux", 32'(rx_sd_mux), 32'(loopback ? sd_out : rx_sd_in));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 hold between strobes", 32'(sd_out), 32'(exp));
        chk_status();
    endtask

    task automatic half();
        logic lr;
        lr = ~m_prev;
        for (int i = 0; i < 32; i++) tick(lr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; tx_en = 1'b0; mute = 1'b0; clr_fifo = 1'b0; dma_mode = 1'b0;
        loopback = 1'b0; cpu_wr = 1'b0; dma_wr = 1'b0; bclk_fall = 1'b0; lrclk = 1'b0;
        rx_sd_in = 1'b0; cpu_wdata = '0; dma_wdata = '0;
        m_sh = '0; m_left = 0; m_prev = 1'b0; m_urun = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset sd", 32'(sd_out), 32'h0);
        chk_status();

        // R1: direct words, MSB first, zero tail
        tx_en = 1'b1;
        push(24'hA5C3F1, 1'b0);
        push(24'h800001, 1'b0);
        push(24'h7FFFFE, 1'b0);
        for (int h = 0; h < 4; h++) half();

        // R2/R3: fill to 16, extra writes dropped
        tx_en = 1'b0;
        for (int i = 0; i < 18; i++) push(24'h100000 + 24'(i * 24'h01111), 1'b0);
        chk_status();
        // R9: disabled word starts consume nothing
        half(); half();
        chk("R9 still full", 32'(fifo_full), 32'h1);
        tx_en = 1'b1;
        for (int h = 0; h < 6; h++) half();

        // R5/R6: DMA mode threshold at 9 and 8
        do_clear();
        dma_mode = 1'b1;
        for (int i = 0; i < 9; i++) push(24'($urandom()), 1'b1);
        chk("R6 nine held", 32'(dma_req), 32'h0);
        half();
        chk("R6 eight held", 32'(dma_req), 32'h1);
        push(24'hDEAD01, 1'b0);
        chk("R5 cpu ignored in dma mode", 32'(dma_req), 32'h1);
        dma_mode = 1'b0;
        push(24'hBEEF02, 1'b1);
        chk("R5 dma ignored in direct mode", 32'(dma_req), 32'h0);
        chk_status();
        for (int h = 0; h < 3; h++) half();

        // R4: mute pops but sends zeros
        mute = 1'b1;
        half(); half();
        mute = 1'b0;
        for (int h = 0; h < 6; h++) half();

        // R7: underrun sticky across refill
        chk("R7 underrun set", 32'(underrun), 32'h1);
        push(24'h123456, 1'b0);
        half(); half();
        chk("R7 still set", 32'(underrun), 32'h1);

        // R8: clear with simultaneous write
        push(24'h0F0F0F, 1'b0);
        @(negedge clk);
        clr_fifo = 1'b1; cpu_wr = 1'b1; cpu_wdata = 24'hFFFFFF;
        @(posedge clk);
        @(negedge clk);
        clr_fifo = 1'b0; cpu_wr = 1'b0;
        m_q.delete(); m_urun = 1'b0;
        chk("R8 empty after clear", 32'(fifo_empty), 32'h1);
        chk("R8 underrun cleared", 32'(underrun), 32'h0);

        // R10: loopback
        loopback = 1'b1;
        push(24'hC0FFEE, 1'b0);
        half(); half();
        loopback = 1'b0;

        // Random mix
        for (int h = 0; h < 150; h++) begin
            int n;
            if (($urandom() % 20) == 0) begin
                dma_mode = ~dma_mode;
            end
            mute     = (($urandom() % 10) == 0);
            loopback = 1'($urandom());
            n = int'($urandom() % 3);
            for (int k = 0; k < n; k++) push(24'($urandom()), 1'($urandom() % 4 != 0) ? dma_mode : ~dma_mode);
            if (($urandom() % 40) == 0) do_clear();
            half();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule